// File: doc/BRIEF.md
# Seven-to-One Video Link Serializer Gearbox

This block turns parallel video pixels into the four data lanes and the forwarded-clock lane of a seven-to-one LVDS video link. Each pixel carries 8-bit red, green and blue values plus the vertical sync, horizontal sync and data-enable flags. These 27 bits, padded to 28, are cut into four 7-bit lane symbols. The block runs on the word clock, which is 1.75 times the pixel rate. On every word-clock cycle each lane emits a 4-bit word for an external double-data-rate output register that is geared two to one.

Seven bits go into each lane per pixel and four bits come out per cycle. Over every 7 word-clock cycles the block therefore takes exactly 4 pixels, in a fixed slot pattern. All five lanes share one fill-level counter. The fifth lane is fed the constant symbol 1100011 in every slot, so the forwarded clock stays bit-aligned with the pixel boundaries on the data lanes.

The logic is held in reset until the PLL reports lock, through a reset synchronizer. The link starts on the first valid pixel after that release. A pixel-valid strobe that disagrees with the slot pattern raises a one-cycle error pulse.

Top module: `lvds71_tx_gearbox`

## Requirements
- R1: All outputs are zero while `rst_n` or `pll_locked` is low. A drop of either clears the outputs at once, without waiting for a clock edge. After both are high, the first word-clock edge that can act on input is the third one (two synchronizer stages).
- R2: After reset, every lane word and `slot_err` stay zero until the first cycle with `pix_valid` high. That first valid pixel is always accepted, and its cycle becomes slot offset 0.
- R3: After the start, pixels are accepted at offsets 0, 1, 3 and 5 of each repeating 7-cycle period, counted from the start cycle. That is exactly 4 accepted pixels per 7 cycles.
- R4: The 28-bit vector {1'b0, de, vsync, hsync, blue[7:0], green[7:0], red[7:0]} is split so that data lane k carries bits 7k+6 down to 7k. Symbol bit 6 is sent first.
- R5: Each lane sends the bits of its symbols in the order the symbols were accepted. Word n (n = 0 in the cycle after the start edge) holds stream bits 4n to 4n+3, with the earliest bit in word bit 3. `lane_word` packs data lane k into bits 4k+3 down to 4k.
- R6: In every slot the clock lane receives the symbol 1100011. Its words therefore repeat the sequence 0xC, 0x7, 0x8, 0xF, 0x1, 0xE, 0x3 from the start.
- R7: A slot with `pix_valid` low puts an all-zero symbol into the data lanes and raises `slot_err` in the next cycle.
- R8: `pix_valid` high outside a slot is ignored: the data lane streams do not change. `slot_err` is raised in the next cycle.
- R9: `slot_err` is high for exactly one cycle after each cycle in which `pix_valid` disagrees with the slot pattern. It is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_word | input | 1 | Word clock, 1.75 times the pixel rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| pll_locked | input | 1 | PLL lock indication; low holds the block in reset |
| pix_valid | input | 1 | A pixel is presented this cycle |
| pix_red | input | 8 | Red component |
| pix_grn | input | 8 | Green component |
| pix_blu | input | 8 | Blue component |
| pix_vsync | input | 1 | Vertical sync flag |
| pix_hsync | input | 1 | Horizontal sync flag |
| pix_de | input | 1 | Data-enable flag |
| lane_word | output | 16 | Four data-lane words, lane k at bits 4k+3:4k |
| clk_lane_word | output | 4 | Forwarded-clock lane word |
| slot_err | output | 1 | Pixel strobe disagreed with the slot pattern last cycle |

## Verification
The bench builds the block with its defaults: two synchronizer stages, 7-bit symbols, 4-bit words and four data lanes. With these values one 7-cycle period takes every residual fill level from 0 to 6, so a few hundred cycles exercise every append position of the 11-bit lane buffer many times over. Two synchronizer stages let the bench pin down the exact first active edge after lock. A lock drop in the middle of a stream and a restart with an idle gap before the first pixel cover both ways the link can start.

// File: rtl/lvds71_pkg.sv
package lvds71_pkg;

  localparam int SYM_W      = 7;
  localparam int WORD_W     = 4;
  localparam int DATA_LANES = 4;
  localparam int NUM_LANES  = DATA_LANES + 1;
  localparam int COLOR_W    = 8;
  localparam int BUF_W      = SYM_W + WORD_W;
  localparam int LVL_W      = $clog2(BUF_W + 1);
  localparam int PH_W       = $clog2(SYM_W);
  localparam int ACC_W      = $clog2(SYM_W + 1);
  localparam int FLAT_W     = DATA_LANES * SYM_W;

  localparam logic [SYM_W-1:0] CLK_PATTERN = 7'b1100011;

  typedef struct packed {
    logic               de;
    logic               vs;
    logic               hs;
    logic [COLOR_W-1:0] blu;
    logic [COLOR_W-1:0] grn;
    logic [COLOR_W-1:0] red;
  } pixel_t;

  localparam int PAD_W = FLAT_W - $bits(pixel_t);

  // Slice one lane's symbol out of the padded pixel vector.
  function automatic logic [SYM_W-1:0] lane_symbol(pixel_t p, int lane);
    logic [FLAT_W-1:0] flat;
    flat = {{PAD_W{1'b0}}, p};
    return flat[lane*SYM_W +: SYM_W];
  endfunction

  // Fill level after one cycle: optional append of a symbol, then one word out.
  function automatic logic [LVL_W-1:0] next_level(logic [LVL_W-1:0] lvl, logic add);
    logic [LVL_W-1:0] sum;
    sum = lvl + (add ? LVL_W'(SYM_W) : LVL_W'(0));
    return sum - LVL_W'(WORD_W);
  endfunction

  // Place a symbol directly behind the bits already held in the buffer.
  function automatic logic [BUF_W-1:0] place_symbol(logic [SYM_W-1:0] s, logic [LVL_W-1:0] lvl);
    return {s, {WORD_W{1'b0}}} >> lvl;
  endfunction

endpackage

// File: rtl/lvds71_rst_sync.sv
module lvds71_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arm_n,
  output logic rst_out_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arm_n) begin
    if (!arm_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_out_n = chain_q[STAGES-1];
endmodule

// File: rtl/lvds71_gear_ctrl.sv
module lvds71_gear_ctrl
  import lvds71_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_valid,
  output logic             started,
  output logic             take,
  output logic             emit,
  output logic [LVL_W-1:0] level,
  output logic             err
);
  logic [PH_W-1:0]  phase_q;
  logic [ACC_W-1:0] acc_q;
  logic             started_q;
  logic [LVL_W-1:0] level_q;
  logic             err_q;

  always_comb begin
    take = started_q ? (level_q < LVL_W'(WORD_W)) : pix_valid;
    emit = started_q | take;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started_q <= 1'b0;
      level_q   <= '0;
      phase_q   <= '0;
      acc_q     <= '0;
      err_q     <= 1'b0;
    end else begin
      err_q <= started_q & (pix_valid ^ take);
      if (emit) begin
        started_q <= 1'b1;
        level_q   <= next_level(level_q, take);
        if (phase_q == PH_W'(SYM_W - 1)) begin
          phase_q <= '0;
          acc_q   <= '0;
        end else begin
          phase_q <= phase_q + 1'b1;
          acc_q   <= acc_q + ACC_W'(take);
        end
      end
    end
  end

  assign started = started_q;
  assign level   = level_q;
  assign err     = err_q;

  // R3: every full period of SYM_W cycles accepts exactly WORD_W pixels
  assert_accept_quota_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (started_q && phase_q == PH_W'(SYM_W - 1)) |-> (int'(acc_q) + int'(take)) == WORD_W);

  // R5: a word is never emitted from a buffer holding fewer than WORD_W bits
  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    started_q |-> (int'(level_q) + (take ? SYM_W : 0)) >= WORD_W);
endmodule

// File: rtl/lvds71_lane_gearbox.sv
module lvds71_lane_gearbox
  import lvds71_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              append,
  input  logic              emit,
  input  logic [LVL_W-1:0]  level,
  input  logic [SYM_W-1:0]  sym,
  output logic [WORD_W-1:0] word
);
  logic [BUF_W-1:0]  buf_q;
  logic [BUF_W-1:0]  merged;
  logic [WORD_W-1:0] word_q;

  always_comb begin
    merged = buf_q | (append ? place_symbol(sym, level) : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q  <= '0;
      word_q <= '0;
    end else if (emit) begin
      word_q <= merged[BUF_W-1 -: WORD_W];
      buf_q  <= merged << WORD_W;
    end else begin
      word_q <= '0;
    end
  end

  assign word = word_q;

  // R5: only the top 'level' bits of the buffer may hold pending data
  assert_buf_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_q << level) == '0);
endmodule

// File: rtl/lvds71_tx_gearbox.sv
module lvds71_tx_gearbox
  import lvds71_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                         clk_word,
  input  logic                         rst_n,
  input  logic                         pll_locked,
  input  logic                         pix_valid,
  input  logic [COLOR_W-1:0]           pix_red,
  input  logic [COLOR_W-1:0]           pix_grn,
  input  logic [COLOR_W-1:0]           pix_blu,
  input  logic                         pix_vsync,
  input  logic                         pix_hsync,
  input  logic                         pix_de,
  output logic [DATA_LANES*WORD_W-1:0] lane_word,
  output logic [WORD_W-1:0]            clk_lane_word,
  output logic                         slot_err
);
  logic             arm_n;
  logic             rst_int_n;
  logic             started;
  logic             take;
  logic             emit;
  logic [LVL_W-1:0] level;
  pixel_t           pix;
  logic [WORD_W-1:0] words [NUM_LANES];

  assign arm_n = rst_n & pll_locked;
  assign pix   = {pix_de, pix_vsync, pix_hsync, pix_blu, pix_grn, pix_red};

  lvds71_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk       (clk_word),
    .arm_n     (arm_n),
    .rst_out_n (rst_int_n)
  );

  lvds71_gear_ctrl u_ctrl (
    .clk       (clk_word),
    .rst_n     (rst_int_n),
    .pix_valid (pix_valid),
    .started   (started),
    .take      (take),
    .emit      (emit),
    .level     (level),
    .err       (slot_err)
  );

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    logic [SYM_W-1:0] sym;
    if (g < DATA_LANES) begin : g_data
      assign sym = pix_valid ? lane_symbol(pix, g) : '0;
      assign lane_word[g*WORD_W +: WORD_W] = words[g];
    end else begin : g_clk
      assign sym = CLK_PATTERN;
      assign clk_lane_word = words[g];
    end
    lvds71_lane_gearbox u_gb (
      .clk    (clk_word),
      .rst_n  (rst_int_n),
      .append (take),
      .emit   (emit),
      .level  (level),
      .sym    (sym),
      .word   (words[g])
    );
  end

  // R2: before the first pixel, an idle cycle leaves every lane silent
  assert_idle_quiet_R2: assert property (@(posedge clk_word) disable iff (!rst_int_n)
    (!started && !pix_valid) |=> (lane_word == '0 && clk_lane_word == '0));

  // R6: once running, the clock lane never sends an all-zero word
  assert_clk_live_R6: assert property (@(posedge clk_word) disable iff (!rst_int_n)
    started |=> clk_lane_word != '0);

  // R9: no error can be flagged before the link has started
  assert_err_quiet_R9: assert property (@(posedge clk_word) disable iff (!rst_int_n)
    !started |=> !slot_err);
endmodule

// File: tb/tb_lvds71_tx_gearbox.sv
`timescale 1ns/1ps
module tb_lvds71_tx_gearbox;
  localparam real HALF = 2.5;

  logic        clk = 1'b0;
  logic        rst_n, pll_locked, pix_valid;
  logic [7:0]  pix_red, pix_grn, pix_blu;
  logic        pix_vsync, pix_hsync, pix_de;
  logic [15:0] lane_word;
  logic [3:0]  clk_lane_word;
  logic        slot_err;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  bit strm [5][16384];
  int wr_ptr, rd_ptr, m_phase;
  bit m_started;

  always #(HALF) clk = ~clk;

  lvds71_tx_gearbox dut (
    .clk_word(clk), .rst_n(rst_n), .pll_locked(pll_locked), .pix_valid(pix_valid),
    .pix_red(pix_red), .pix_grn(pix_grn), .pix_blu(pix_blu),
    .pix_vsync(pix_vsync), .pix_hsync(pix_hsync), .pix_de(pix_de),
    .lane_word(lane_word), .clk_lane_word(clk_lane_word), .slot_err(slot_err));

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Pixel bit i of the padded 28-bit vector (R4 layout)
  function automatic bit pix_bit(int i);
    if (i < 8)  return pix_red[i];
    if (i < 16) return pix_grn[i-8];
    if (i < 24) return pix_blu[i-16];
    if (i == 24) return pix_hsync;
    if (i == 25) return pix_vsync;
    if (i == 26) return pix_de;
    return 1'b0;
  endfunction

  function automatic bit in_slot(int ph);
    return (ph == 0) || (ph == 1) || (ph == 3) || (ph == 5);
  endfunction

  task automatic model_clear();
    wr_ptr = 0; rd_ptr = 0; m_phase = 0; m_started = 0;
  endtask

  task automatic check_zero(string tag);
    chk(lane_word == 16'h0, tag, "data lanes zero", lane_word, 0);
    chk(clk_lane_word == 4'h0, tag, "clock lane zero", clk_lane_word, 0);
    chk(slot_err == 1'b0, tag, "slot_err low", slot_err, 0);
  endtask

  // Called at a negedge: drive, predict the next edge, then check at the following negedge.
  task automatic step(bit v, logic [7:0] r, logic [7:0] g, logic [7:0] b, bit hs, bit vs, bit de);
    bit slot, emit, exp_err, was_started;
    logic [15:0] exp_data;
    logic [3:0]  exp_clk;
    string dtag, etag;
    pix_valid = v; pix_red = r; pix_grn = g; pix_blu = b;
    pix_hsync = hs; pix_vsync = vs; pix_de = de;
    was_started = m_started;
    slot = m_started ? in_slot(m_phase) : v;
    emit = m_started || slot;
    if (slot) begin
      for (int j = 0; j < 7; j++) begin
        for (int l = 0; l < 4; l++) strm[l][wr_ptr+j] = v ? pix_bit(7*l + 6 - j) : 1'b0;
        strm[4][wr_ptr+j] = (7'b1100011 >> (6 - j)) & 1;
      end
      wr_ptr += 7;
    end
    exp_data = '0; exp_clk = '0;
    if (emit) begin
      for (int l = 0; l < 4; l++)
        for (int k = 0; k < 4; k++) exp_data[4*l + 3 - k] = strm[l][4*rd_ptr + k];
      for (int k = 0; k < 4; k++) exp_clk[3 - k] = strm[4][4*rd_ptr + k];
      rd_ptr++;
      m_phase = (m_phase == 6) ? 0 : m_phase + 1;
    end
    exp_err = m_started && (v != slot);
    m_started = m_started || slot;
    if (!was_started && !v) dtag = "R2";
    else if (was_started && slot && !v) dtag = "R7";
    else if (was_started && !slot && v) dtag = "R8";
    else dtag = "R3/R4/R5";
    if (!exp_err) etag = "R9";
    else if (v) etag = "R8";
    else etag = "R7";
    @(negedge clk);
    chk(lane_word == exp_data, dtag, "data lane words", lane_word, exp_data);
    chk(clk_lane_word == exp_clk, "R6", "clock lane word", clk_lane_word, exp_clk);
    chk(slot_err == exp_err, etag, "slot_err", slot_err, exp_err);
  endtask

  task automatic rand_step(int flip_mod);
    bit v;
    v = m_started ? in_slot(m_phase) : 1'b1;
    if (($urandom % flip_mod) == 0) v = !v;
    step(v, 8'($urandom), 8'($urandom), 8'($urandom),
         1'($urandom), 1'($urandom), 1'($urandom));
  endtask

  // Raise lock at a negedge; the logic acts on the third edge (R1).
  task automatic relock(bit v);
    model_clear();
    pll_locked = 1'b1;
    pix_valid = v; pix_red = 8'hA5; pix_grn = 8'h3C; pix_blu = 8'h96;
    pix_hsync = 1; pix_vsync = 0; pix_de = 1;
    @(negedge clk); check_zero("R1");
    @(negedge clk); check_zero("R1");
  endtask

  initial begin
    void'($urandom(32'h1234_5eed));
    rst_n = 0; pll_locked = 0; pix_valid = 0;
    pix_red = 0; pix_grn = 0; pix_blu = 0; pix_hsync = 0; pix_vsync = 0; pix_de = 0;
    model_clear();
    repeat (3) begin @(negedge clk); check_zero("R1"); end
    rst_n = 1; pix_valid = 1; pix_red = 8'hFF;
    repeat (4) begin @(negedge clk); check_zero("R1"); end

    // Start immediately on lock; R1 timing then R2 start
    relock(1'b1);
    step(1, 8'hA5, 8'h3C, 8'h96, 1, 0, 1);
    // Directed: follow the slot pattern for two periods
    for (int i = 0; i < 13; i++)
      step(in_slot(m_phase), 8'(i*17), 8'(255 - i), 8'(i*3), i[0], i[1], i[2]);
    // R8: strobe outside a slot with loud data
    while (in_slot(m_phase)) step(1, 8'h11, 8'h22, 8'h33, 0, 0, 1);
    step(1, 8'hFF, 8'hFF, 8'hFF, 1, 1, 1);
    // R7: missing strobe in a slot
    while (!in_slot(m_phase)) step(0, 8'h00, 8'h00, 8'h00, 0, 0, 0);
    step(0, 8'hFF, 8'hFF, 8'hFF, 1, 1, 1);
    // Random stream
    for (int i = 0; i < 1200; i++) rand_step(20);

    // R1: lock lost mid-stream clears outputs at once
    pll_locked = 0;
    #1;
    check_zero("R1");
    repeat (3) begin @(negedge clk); pix_valid = ~pix_valid; check_zero("R1"); end

    // R2: restart with an idle gap before the first pixel
    relock(1'b0);
    for (int i = 0; i < 6; i++) step(0, 8'hEE, 8'hDD, 8'hCC, 1, 1, 1);
    step(1, 8'h01, 8'h80, 8'h7E, 0, 1, 0);
    for (int i = 0; i < 800; i++) rand_step(12);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(HALF * 2.0 * 200000.0);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule